// File: doc/BRIEF.md
# Automatic Sector Signature Verifier

This controller sits next to one signature-compressor channel and drives hands-off integrity checking of memory, one sector at a time. It counts the compressing writes the channel accepts. When a programmed number of writes has gone through, it copies the compressor's signature into a held sector-signature register and clears the compressor in the same step. It then compares the held value with an expected CRC value that a DMA engine has loaded.

The controller requests each expected value through a level DMA request. That request stays up until the expected-value register is written. A compare never runs before that write has happened. A mismatch sets a sticky fail flag, and that flag drives an interrupt when the interrupt is enabled. In full-CPU mode the controller does nothing on its own: software feeds the compressor and checks the results itself.

Top module: `sector_sig_verifier`

## Requirements
- R1: After reset, with auto_mode_i high and no expected value written, dma_req_o is high from the first cycle.
- R2: In auto mode a sector ends on the sector_len_i-th accepted pat_wr_i write (sector_len_i is at least 1). In the cycle after that write, sig_clr_o is high for exactly one cycle. At the closing edge of that cycle, sec_sig_o captures sig_i.
- R3: The compare runs in the cycle after capture if an expected value is already held. Otherwise it runs in the cycle after the first exp_wr_i. cmp_done_o is a one-cycle pulse that follows the compare edge. No compare runs without a fresh expected value.
- R4: dma_req_o stays high until exp_wr_i is sampled. It falls in the cycle after that write. It rises again together with cmp_done_o, when the compare consumes the held value.
- R5: The compare covers all 64 bits, including bit 63. A mismatch makes fail_flag_o high in the same cycle as cmp_done_o. A match leaves the flag unchanged.
- R6: fail_flag_o is sticky and is cleared by a pulse on fail_clr_i. If a set and a clear fall in the same cycle, the set wins. fail_irq_o equals fail_flag_o AND irq_en_i AND auto_mode_i.
- R7: With auto_mode_i low, the outputs dma_req_o, fail_irq_o, sig_clr_o and cmp_done_o stay low. The write counter is held at zero, so a later auto-mode sector counts from its own first write.
- R8: A sector length of 1 ends a sector on every write. The maximum length the counter width allows, 2^CNT_W-1, ends a sector only on that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_mode_i | input | 1 | 1 = automatic mode, 0 = full-CPU mode |
| sector_len_i | input | CNT_W | Compressing writes per sector |
| pat_wr_i | input | 1 | A compressing write was accepted by the compressor |
| sig_i | input | SIG_W | Current working signature of the compressor |
| sig_clr_o | output | 1 | Clears the compressor's working signature |
| exp_wr_i | input | 1 | Write strobe for the expected CRC value |
| exp_i | input | SIG_W | Expected CRC value data |
| sec_sig_o | output | SIG_W | Held sector signature |
| dma_req_o | output | 1 | Request for the next expected CRC value |
| cmp_done_o | output | 1 | One-cycle pulse after each compare |
| irq_en_i | input | 1 | Fail interrupt enable |
| fail_clr_i | input | 1 | Write-1 clear of the fail flag |
| fail_flag_o | output | 1 | Sticky compare-fail status |
| fail_irq_o | output | 1 | CRC-fail interrupt |

## Verification
The bench builds the block with CNT_W = 4 and keeps SIG_W at 64. The 4-bit counter puts both ends of the sector-length range, 1 and 15, within a short run. The full signature width makes a mismatch in the top bit alone a meaningful case. A small compressor model in the bench produces the signatures. Sectors are run with the expected value written both before and after the sector ends, so both compare timings are exercised.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
endpackage

// File: rtl/ssv_sector_cnt.sv
module ssv_sector_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pat_wr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             sec_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             end_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(len_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      end_q <= pat_wr_i & last;
      if (pat_wr_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign sec_end_o = end_q;

  a_r2_end_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> $past(pat_wr_i));
endmodule

// File: rtl/ssv_seq.sv
module ssv_seq
  import ssv_pkg::*;
#(
  parameter int SIG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             sec_end_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             exp_wr_i,
  input  logic [SIG_W-1:0] exp_i,
  output logic             sig_clr_o,
  output logic [SIG_W-1:0] sec_sig_o,
  output logic [SIG_W-1:0] exp_o,
  output logic             exp_valid_o,
  output logic             cmp_fire_o,
  output logic             cmp_done_o
);
  seq_state_e       state_q;
  logic [SIG_W-1:0] sec_sig_q, exp_q;
  logic             exp_valid_q, done_q;
  logic             capture;

  assign capture    = auto_i & sec_end_i;
  assign cmp_fire_o = auto_i & (state_q == ST_WAIT) & exp_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sec_sig_q   <= '0;
      exp_q       <= '0;
      exp_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= cmp_fire_o;
      if (exp_wr_i) begin
        exp_q       <= exp_i;
        exp_valid_q <= 1'b1;
      end else if (cmp_fire_o) begin
        exp_valid_q <= 1'b0;
      end
      if (capture) sec_sig_q <= sig_i;
      if (!auto_i)         state_q <= ST_IDLE;
      else if (capture)    state_q <= ST_WAIT;
      else if (cmp_fire_o) state_q <= ST_IDLE;
    end
  end

  assign sig_clr_o   = capture;
  assign sec_sig_o   = sec_sig_q;
  assign exp_o       = exp_q;
  assign exp_valid_o = exp_valid_q;
  assign cmp_done_o  = done_q;

  a_r2_capture_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_clr_o |=> (sec_sig_o == $past(sig_i)));
  a_r3_done_needs_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_done_o |-> $past(exp_valid_q));
endmodule

// File: rtl/ssv_cmp.sv
module ssv_cmp #(
  parameter int SIG_W = 64
) (
  input  logic [SIG_W-1:0] sec_sig_i,
  input  logic [SIG_W-1:0] exp_i,
  output logic             mismatch_o
);
  assign mismatch_o = |(sec_sig_i ^ exp_i);
endmodule

// File: rtl/ssv_fail_irq.sv
module ssv_fail_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic auto_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i & auto_i;

  a_r5_set_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/sector_sig_verifier.sv
module sector_sig_verifier #(
  parameter int SIG_W = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_mode_i,
  input  logic [CNT_W-1:0] sector_len_i,
  input  logic             pat_wr_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic             sig_clr_o,
  input  logic             exp_wr_i,
  input  logic [SIG_W-1:0] exp_i,
  output logic [SIG_W-1:0] sec_sig_o,
  output logic             dma_req_o,
  output logic             cmp_done_o,
  input  logic             irq_en_i,
  input  logic             fail_clr_i,
  output logic             fail_flag_o,
  output logic             fail_irq_o
);
  logic             sec_end, exp_valid, cmp_fire, mismatch;
  logic [SIG_W-1:0] exp_q;

  ssv_sector_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (auto_mode_i),
    .pat_wr_i  (pat_wr_i),
    .len_i     (sector_len_i),
    .sec_end_o (sec_end)
  );

  ssv_seq #(.SIG_W(SIG_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_i      (auto_mode_i),
    .sec_end_i   (sec_end),
    .sig_i       (sig_i),
    .exp_wr_i    (exp_wr_i),
    .exp_i       (exp_i),
    .sig_clr_o   (sig_clr_o),
    .sec_sig_o   (sec_sig_o),
    .exp_o       (exp_q),
    .exp_valid_o (exp_valid),
    .cmp_fire_o  (cmp_fire),
    .cmp_done_o  (cmp_done_o)
  );

  ssv_cmp #(.SIG_W(SIG_W)) u_cmp (
    .sec_sig_i  (sec_sig_o),
    .exp_i      (exp_q),
    .mismatch_o (mismatch)
  );

  ssv_fail_irq u_fail (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cmp_fire & mismatch),
    .clr_i    (fail_clr_i),
    .irq_en_i (irq_en_i),
    .auto_i   (auto_mode_i),
    .flag_o   (fail_flag_o),
    .irq_o    (fail_irq_o)
  );

  assign dma_req_o = auto_mode_i & ~exp_valid;

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !exp_wr_i && auto_mode_i) |=> (dma_req_o || !auto_mode_i));
  a_r7_cpu_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_mode_i |-> (!dma_req_o && !fail_irq_o && !sig_clr_o));
endmodule

// File: tb/sector_sig_verifier_bench.sv
module sector_sig_verifier_bench;
  localparam int SIG_W = 64;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [SIG_W-1:0] sig;
    logic             flag;
  } exp_item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             auto_mode = 1'b1;
  logic [CNT_W-1:0] sector_len = 4'd3;
  logic             pat_wr = 1'b0;
  logic [SIG_W-1:0] pat = '0;
  logic [SIG_W-1:0] work;
  logic             sig_clr;
  logic             exp_wr = 1'b0;
  logic [SIG_W-1:0] exp_d = '0;
  logic [SIG_W-1:0] sec_sig;
  logic             dma_req, cmp_done;
  logic             irq_en = 1'b1;
  logic             fail_clr = 1'b0;
  logic             fail_flag, fail_irq;
  logic             soft_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int clr_cnt = 0;
  logic model_flag = 1'b0;
  exp_item_t sb_q[$];

  always #5 clk = ~clk;

  sector_sig_verifier #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_sector_sig_verifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .auto_mode_i (auto_mode),
    .sector_len_i(sector_len),
    .pat_wr_i    (pat_wr),
    .sig_i       (work),
    .sig_clr_o   (sig_clr),
    .exp_wr_i    (exp_wr),
    .exp_i       (exp_d),
    .sec_sig_o   (sec_sig),
    .dma_req_o   (dma_req),
    .cmp_done_o  (cmp_done),
    .irq_en_i    (irq_en),
    .fail_clr_i  (fail_clr),
    .fail_flag_o (fail_flag),
    .fail_irq_o  (fail_irq)
  );

  // stand-in compressor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 work <= '0;
    else if (sig_clr || soft_clr) work <= pat_wr ? pat : '0;
    else if (pat_wr)            work <= {work[SIG_W-2:0], work[SIG_W-1]} ^ pat;
  end

  task automatic check(input string req, input logic [SIG_W-1:0] act, input logic [SIG_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sig_clr) clr_cnt++;
      if (cmp_done) begin
        done_cnt++;
        if (sb_q.size() == 0) begin
          check("R3 unexpected compare", 64'd1, 64'd0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check("R2 sector signature", sec_sig, it.sig);
          check("R5 fail flag after compare", {63'd0, fail_flag}, {63'd0, it.flag});
          check("R4 request back with compare", {63'd0, dma_req}, 64'd1);
        end
      end
    end
  end

  task automatic write_exp(input logic [SIG_W-1:0] v);
    @(negedge clk);
    exp_wr = 1'b1; exp_d = v;
    @(negedge clk);
    exp_wr = 1'b0;
    check("R4 request drops after write", {63'd0, dma_req}, 64'd0);
  endtask

  task automatic run_sector(input int n, input logic [SIG_W-1:0] base,
                            input logic [SIG_W-1:0] flip, input bit exp_first);
    logic [SIG_W-1:0] s;
    exp_item_t it;
    int d0, c0, t;
    s = '0;
    for (int i = 0; i < n; i++) s = {s[SIG_W-2:0], s[SIG_W-1]} ^ (base + SIG_W'(i));
    d0 = done_cnt;
    c0 = clr_cnt;
    if (exp_first) write_exp(s ^ flip);
    model_flag = model_flag | (flip != '0);
    it.sig = s; it.flag = model_flag;
    sb_q.push_back(it);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) check("R8 no early sector end", clr_cnt - c0, 0);
      pat_wr = 1'b1; pat = base + SIG_W'(i);
    end
    @(negedge clk);
    pat_wr = 1'b0;
    if (!exp_first) begin
      repeat (4) @(negedge clk);
      check("R3 no compare before expected write", done_cnt - d0, 0);
      check("R4 request held while waiting", {63'd0, dma_req}, 64'd1);
      write_exp(s ^ flip);
    end
    t = 0;
    while (done_cnt == d0 && t < 30) begin
      @(negedge clk);
      t++;
    end
    check("R3 compare happened", done_cnt - d0, 1);
    check("R2 one clear per sector", clr_cnt - c0, 1);
  endtask

  task automatic clear_fail();
    @(negedge clk);
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
    model_flag = 1'b0;
    check("R6 flag cleared", {63'd0, fail_flag}, 64'd0);
    check("R6 irq cleared", {63'd0, fail_irq}, 64'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 request after reset", {63'd0, dma_req}, 64'd1);
    check("R6 flag reset", {63'd0, fail_flag}, 64'd0);
    check("R6 irq reset", {63'd0, fail_irq}, 64'd0);
    check("R2 no clear at reset", {63'd0, sig_clr}, 64'd0);

    run_sector(3, 64'h1111_0000_0000_0001, '0, 1'b1);
    check("R5 match leaves flag", {63'd0, fail_flag}, 64'd0);

    run_sector(3, 64'h2222_0000_0000_0100, 64'h8000_0000_0000_0000, 1'b1);
    check("R5 top-bit mismatch", {63'd0, fail_flag}, 64'd1);
    check("R6 irq enabled", {63'd0, fail_irq}, 64'd1);
    clear_fail();

    irq_en = 1'b0;
    run_sector(3, 64'h3333_0000_0000_0007, 64'd1, 1'b0);
    check("R6 irq gated", {63'd0, fail_irq}, 64'd0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R6 irq on enable", {63'd0, fail_irq}, 64'd1);
    run_sector(3, 64'h3434_0000_0000_0009, '0, 1'b1);
    check("R6 flag sticky", {63'd0, fail_flag}, 64'd1);
    clear_fail();

    sector_len = 4'd1;
    run_sector(1, 64'h4444_0000_0000_0003, '0, 1'b1);
    run_sector(1, 64'h5555_0000_0000_0005, '0, 1'b0);
    sector_len = 4'd15;
    run_sector(15, 64'h6666_0000_0000_0011, '0, 1'b1);

    auto_mode = 1'b0;
    sector_len = 4'd3;
    @(negedge clk);
    check("R7 no request in CPU mode", {63'd0, dma_req}, 64'd0);
    begin
      int c0, d0;
      c0 = clr_cnt; d0 = done_cnt;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        pat_wr = 1'b1; pat = 64'hdead_0000 + SIG_W'(i);
      end
      @(negedge clk);
      pat_wr = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 no clear in CPU mode", clr_cnt - c0, 0);
      check("R7 no compare in CPU mode", done_cnt - d0, 0);
    end
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    auto_mode = 1'b1;
    @(negedge clk);
    check("R7 request back in auto", {63'd0, dma_req}, 64'd1);
    run_sector(3, 64'h7777_0000_0000_0021, '0, 1'b1);
    check("R7 counter restarted", {63'd0, fail_flag}, 64'd0);

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule